// File: doc/BRIEF.md
# Per-Lane Variable Logical Right Shifter

This block is a SIMD shift datapath. It takes a 256-bit data vector and a 256-bit count vector. Each element of the data vector is shifted right by the unsigned count held in the element at the same position of the count vector. Vacated high-order bits are filled with zeros.

A lane-size input selects 32-bit or 64-bit elements. A length input selects narrow (128-bit) or wide (256-bit) operation. In narrow operation the upper half of the result is cleared.

Every lane compares its whole count element against the element width. It does not mask the count to its low bits. A lane whose count reaches the element width or more yields zero.

The result is registered and comes out one cycle after the input strobe. The unit has no back-pressure and accepts a new vector on every cycle. The out_valid strobe follows in_valid with a one-cycle delay. When in_valid is low, the result register keeps its last value.

Top module: `vshr_top`

## Requirements
- R1: With elem64=0, result lane i (bits 32*i+31:32*i) equals the data lane shifted right logically by the unsigned 32-bit count in the same bit range, with zeros shifted in at the top.
- R2: With elem64=1, result lane i (bits 64*i+63:64*i) equals the data lane shifted right logically by the unsigned 64-bit count in the same bit range.
- R3: With elem64=0, a lane whose full 32-bit count is 32 or more gives zero. A count such as 32'h8000_0020 must not wrap to a small shift.
- R4: With elem64=1, a lane whose full 64-bit count is 64 or more gives zero. This includes counts with only bits above bit 31 set.
- R5: A count of zero returns the lane unchanged, in either lane size.
- R6: With len256=0, only bits 127:0 are processed (four 32-bit or two 64-bit lanes), and result bits 255:128 are zero.
- R7: With len256=1, all 256 bits are processed (eight 32-bit or four 64-bit lanes).
- R8: out_valid is high exactly in the cycle after a cycle with in_valid high, and result is updated at that same edge. While in_valid is low, result holds its value.
- R9: While rst_n is low, out_valid and result are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector strobe |
| elem64 | input | 1 | Lane size: 0 selects 32-bit lanes, 1 selects 64-bit lanes |
| len256 | input | 1 | Length: 0 selects 128-bit operation, 1 selects 256-bit operation |
| data | input | 256 | Data vector to shift |
| count | input | 256 | Per-lane shift counts |
| result | output | 256 | Registered shifted vector |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |

## Verification
The clocked assertions assume that elem64, len256, data and count are known, non-X values in every cycle where in_valid is high. They compare the registered result against those inputs one cycle later.

The unit never stalls, so nothing is assumed about back-pressure. The bench drives every input at the falling edge and keeps each value for a full cycle. It sweeps counts 0 through 79 in every lane with a different offset per lane. It adds counts with only high bits set, in all four lane-size and length combinations.

// File: rtl/vshr_pkg.sv
package vshr_pkg;
  localparam int VEC_W = 256;
  localparam int SEG_W = 64;
  localparam int NSEG  = VEC_W / SEG_W;
  typedef enum logic {LANE32 = 1'b0, LANE64 = 1'b1} lane_e;
endpackage

// File: rtl/vshr_lane.sv
module vshr_lane #(
  parameter int W = 32
) (
  input  logic [W-1:0] d,
  input  logic [W-1:0] c,
  output logic [W-1:0] q
);
  localparam int LOG = $clog2(W);

  logic [W-1:0] stage [LOG+1];
  logic         over;

  assign stage[0] = d;
  for (genvar s = 0; s < LOG; s++) begin : g_stage
    assign stage[s+1] = c[s] ? (stage[s] >> (1 << s)) : stage[s];
  end

  // any bit at or above LOG means the count is at least W
  assign over = |c[W-1:LOG];
  assign q    = over ? '0 : stage[LOG];

  always_comb begin
    if (c == '0) begin
      assert_zero_count_identity_R5: assert (q == d);
    end
    if (c >= W) begin
      assert_range_clears_R3: assert (q == '0);
    end
  end
endmodule

// File: rtl/vshr_seg.sv
module vshr_seg
  import vshr_pkg::*;
#(
  parameter int SW = SEG_W
) (
  input  lane_e          mode,
  input  logic [SW-1:0]  d,
  input  logic [SW-1:0]  c,
  output logic [SW-1:0]  q
);
  localparam int HW = SW / 2;

  logic [HW-1:0] q_lo, q_hi;
  logic [SW-1:0] q_wide;

  vshr_lane #(.W(HW)) u_lo   (.d(d[HW-1:0]),  .c(c[HW-1:0]),  .q(q_lo));
  vshr_lane #(.W(HW)) u_hi   (.d(d[SW-1:HW]), .c(c[SW-1:HW]), .q(q_hi));
  vshr_lane #(.W(SW)) u_wide (.d(d),          .c(c),          .q(q_wide));

  assign q = (mode == LANE64) ? q_wide : {q_hi, q_lo};

  always_comb begin
    if (mode == LANE64 && c >= SW) begin
      assert_wide_range_R4: assert (q == '0);
    end
  end
endmodule

// File: rtl/vshr_top.sv
module vshr_top
  import vshr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             elem64,
  input  logic             len256,
  input  logic [VEC_W-1:0] data,
  input  logic [VEC_W-1:0] count,
  output logic [VEC_W-1:0] result,
  output logic             out_valid
);
  localparam int HALF = NSEG / 2;

  lane_e            mode;
  logic [VEC_W-1:0] shifted;

  assign mode = elem64 ? LANE64 : LANE32;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [SEG_W-1:0] q_seg;
    vshr_seg #(.SW(SEG_W)) u_seg (
      .mode (mode),
      .d    (data [g*SEG_W +: SEG_W]),
      .c    (count[g*SEG_W +: SEG_W]),
      .q    (q_seg)
    );
    if (g < HALF) begin : g_low
      assign shifted[g*SEG_W +: SEG_W] = q_seg;
    end else begin : g_high
      assign shifted[g*SEG_W +: SEG_W] = len256 ? q_seg : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= shifted;
    end
  end

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  assert_upper_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !len256) |=> (result[VEC_W-1:VEC_W/2] == '0));
  assert_lane0_zero_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !elem64 && count[31:0] == '0) |=> (result[31:0] == $past(data[31:0])));
endmodule

// File: tb/tb_vshr_top.sv
module tb_vshr_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         elem64 = 1'b0;
  logic         len256 = 1'b0;
  logic [255:0] data = '0;
  logic [255:0] count = '0;
  logic [255:0] result;
  logic         out_valid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  vshr_top dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .elem64(elem64),
    .len256(len256), .data(data), .count(count), .result(result), .out_valid(out_valid));

  always #10 clk = ~clk;

  function automatic logic [255:0] model(input logic [255:0] d, input logic [255:0] c,
                                         input logic e64, input logic l256);
    logic [255:0] r = '0;
    if (!e64) begin
      for (int i = 0; i < 8; i++) begin
        logic [31:0] cv = c[32*i +: 32];
        if (l256 || i < 4) r[32*i +: 32] = (cv > 31) ? 32'd0 : d[32*i +: 32] >> cv;
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        logic [63:0] cv = c[64*i +: 64];
        if (l256 || i < 2) r[64*i +: 64] = (cv > 63) ? 64'd0 : d[64*i +: 64] >> cv;
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic apply(input logic [255:0] d, input logic [255:0] c,
                       input logic e64, input logic l256, input string tag);
    logic [255:0] exp;
    @(negedge clk);
    data = d; count = c; elem64 = e64; len256 = l256; in_valid = 1'b1;
    exp = model(d, c, e64, l256);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R8 valid"}, {255'd0, out_valid}, 256'd1);
    check(tag, result, exp);
  endtask

  function automatic string tagof(input logic e64, input logic l256);
    string s = e64 ? "R2 R4" : "R1 R3";
    return {s, l256 ? " R7" : " R6"};
  endfunction

  initial begin
    logic [255:0] held;
    repeat (3) @(negedge clk);
    check("R9 reset result", result, '0);
    check("R9 reset valid", {255'd0, out_valid}, '0);
    rst_n = 1'b1;

    for (int m = 0; m < 4; m++) begin
      logic e64 = m[0];
      logic l256 = m[1];
      // sweep counts 0..79, with a different count in each lane
      for (int k = 0; k < 80; k++) begin
        logic [255:0] c = '0;
        if (!e64) for (int i = 0; i < 8; i++) c[32*i +: 32] = 32'((k + 11*i) % 80);
        else      for (int i = 0; i < 4; i++) c[64*i +: 64] = 64'((k + 23*i) % 80);
        apply(rnd256(), c, e64, l256, tagof(e64, l256));
      end
      // boundary counts: 0 (R5), width-1, width, high-bit-only values
      begin
        logic [255:0] c = '0;
        if (!e64) begin
          c = {32'h8000_0000, 32'h0001_0000, 32'd32, 32'd31, 32'h8000_0001, 32'd0, 32'h0000_0100, 32'd0};
        end else begin
          c = {64'h1_0000_0000, 64'd64, 64'd63, 64'd0};
        end
        apply(rnd256(), c, e64, l256, {tagof(e64, l256), " R5 edge"});
        apply('1, c, e64, l256, {tagof(e64, l256), " R5 ones"});
      end
      if (e64) begin
        logic [255:0] c = {64'h8000_0000_0000_0000, 64'h0000_0001_0000_0001, 64'd0, 64'h0000_0001_0000_0000};
        apply(rnd256(), c, e64, l256, {tagof(e64, l256), " R4 high"});
      end
    end

    // R8: result holds while in_valid is low
    apply(rnd256(), '0, 1'b0, 1'b1, "R8 load");
    held = result;
    @(negedge clk);
    data = rnd256(); count = '0; len256 = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 hold result", result, held);
    check("R8 valid low", {255'd0, out_valid}, '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule